// File: doc/BRIEF.md
# Latched Real-Time Clock Registers for a Cartridge Bank Controller

This block adds a battery-style time-of-day counter to a cartridge bank controller. It keeps seconds, minutes, hours and a 9-bit day count, advanced by a one-pulse-per-second `tick` input. The CPU talks to it through four register regions selected by `reg_sel`: an access-enable register, a ROM bank register, a map register that points the external RAM window at either a RAM bank or one clock field, and a latch register that freezes a copy of the running time.

Reads of the window while a clock field is mapped return the frozen copy, so software can read all fields coherently while the counter keeps running. Writes to the window while a clock field is mapped set the running counter directly. A control byte carries the top day bit, a halt bit that stops counting, and a sticky wrap flag raised when the day count rolls past its end.

Top module: `cart_rtc_regs`

## Requirements
- R1: A write to region 0 (`reg_sel`=0) enables window access when bit 1 and bit 3 of the data are both 1; any other value disables it.
- R2: A write to region 1 sets the ROM bank to the low 7 data bits, except that a zero result gives bank 1.
- R3: A write to region 2 with a value below 8 sets `ram_bank` to that value and maps RAM into the window: reads return `ram_rdata` and window writes raise `ram_we`.
- R4: A write to region 2 with a value 0x08..0x0C while access is enabled maps a clock field: 0x08 seconds, 0x09 minutes, 0x0A hours, 0x0B day bits 7:0, 0x0C control. Such a value while disabled, or any value above 0x0C, leaves the mapping unchanged.
- R5: Region 3 holds a one-bit stored latch value; only data 0x00 and 0x01 change it. The snapshot is copied from the running time only when 0x01 is written while the stored value is 0.
- R6: With a clock field mapped, reads return the snapshot: seconds, minutes and hours zero-extended, day bits 7:0, or the control byte with bit 7 wrap flag, bit 6 halt, bit 0 day bit 8 and other bits zero.
- R7: With a clock field mapped, a window write sets that running field (seconds 6 bits, minutes 6 bits, hours 5 bits, day low byte, or control bits 0 and 6); when a tick arrives in the same cycle the tick's advance applies and the written field takes the written value.
- R8: On a tick, seconds at 59 or above go to 0 and carry into minutes; minutes at 59 or above go to 0 and carry into hours; hours at 23 or above go to 0 and carry into the 9-bit day count.
- R9: A carry from day 511 wraps the day count to 0 and sets the wrap flag; a control write can set the flag but never clear it, only reset does.
- R10: While access is disabled, window reads return 0 and window writes change neither the counters nor `ram_we`.
- R11: While control bit 6 (halt) is 1, ticks do not change the running time.
- R12: After reset: access disabled, ROM bank 1, RAM bank 0, RAM mapped, stored latch value 0, running time and snapshot all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| reg_we | input | 1 | Register region write strobe |
| reg_sel | input | 2 | Region: 0 enable, 1 ROM bank, 2 map, 3 latch |
| reg_wdata | input | 8 | Register write data |
| win_we | input | 1 | Window write strobe |
| win_wdata | input | 8 | Window write data |
| ram_rdata | input | 8 | Data read from the external RAM bank |
| win_rdata | output | 8 | Window read data |
| ram_we | output | 1 | Write strobe to the external RAM |
| ram_bank | output | 3 | Selected RAM bank |
| rom_bank | output | 7 | Selected ROM bank, never zero |

## Verification
The bench targets the latch sequence: a repeated 0x01 must not re-copy, and an intervening value such as 0x02 must not re-arm it; a design that latched on every 0x01 would show moving values where frozen ones are expected. It drives every rollover boundary up to the day 511 wrap and then writes the control byte with bit 7 clear, so a design that let software clear the wrap flag would read 0x00 instead of 0x80 in bit 7. It collides a tick with a field write to show the written value wins while carries still reach other fields, and issues clock selects while disabled and above 0x0C, which a loose decoder would turn into a mapping change visible as RAM data or a wrong field.

// File: rtl/cart_rtc_pkg.sv
package cart_rtc_pkg;

    localparam int BYTE_W     = 8;
    localparam int SEC_W      = 6;
    localparam int MIN_W      = 6;
    localparam int HOUR_W     = 5;
    localparam int DAY_W      = 9;
    localparam int RAM_BANK_W = 3;
    localparam int RAM_BANKS  = 1 << RAM_BANK_W;

    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;

    localparam logic [BYTE_W-1:0] SEL_FIRST = 8'h08;
    localparam logic [BYTE_W-1:0] SEL_LAST  = 8'h0C;
    localparam logic [BYTE_W-1:0] LATCH_LO  = 8'h00;
    localparam logic [BYTE_W-1:0] LATCH_HI  = 8'h01;
    localparam logic [BYTE_W-1:0] EN_MASK   = 8'h0A;

    localparam int CTRL_DAY_HI = 0;
    localparam int CTRL_HALT   = 6;
    localparam int CTRL_WRAP   = 7;

    typedef enum logic [1:0] {
        RGN_ENABLE = 2'd0,
        RGN_ROM    = 2'd1,
        RGN_MAP    = 2'd2,
        RGN_LATCH  = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_DAYLO = 3'd3,
        F_CTRL  = 3'd4
    } field_e;

    typedef struct packed {
        logic              wrap;
        logic              halt;
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } rtc_time_t;

    // one-second advance with ripple carry through all fields
    function automatic rtc_time_t rtc_advance(input rtc_time_t t);
        rtc_time_t n;
        logic      c_min;
        logic      c_hour;
        logic      c_day;
        n      = t;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        if (t.sec >= SEC_W'(SEC_LAST)) begin
            n.sec = '0;
            c_min = 1'b1;
        end else begin
            n.sec = t.sec + 1'b1;
        end
        if (c_min) begin
            if (t.min >= MIN_W'(MIN_LAST)) begin
                n.min  = '0;
                c_hour = 1'b1;
            end else begin
                n.min = t.min + 1'b1;
            end
        end
        if (c_hour) begin
            if (t.hour >= HOUR_W'(HOUR_LAST)) begin
                n.hour = '0;
                c_day  = 1'b1;
            end else begin
                n.hour = t.hour + 1'b1;
            end
        end
        if (c_day) begin
            if (&t.day) begin
                n.day  = '0;
                n.wrap = 1'b1;
            end else begin
                n.day = t.day + 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic [BYTE_W-1:0] rtc_read_field(input rtc_time_t t, input field_e f);
        logic [BYTE_W-1:0] b;
        b = '0;
        case (f)
            F_SEC:   b = BYTE_W'(t.sec);
            F_MIN:   b = BYTE_W'(t.min);
            F_HOUR:  b = BYTE_W'(t.hour);
            F_DAYLO: b = t.day[BYTE_W-1:0];
            F_CTRL: begin
                b[CTRL_WRAP]   = t.wrap;
                b[CTRL_HALT]   = t.halt;
                b[CTRL_DAY_HI] = t.day[DAY_W-1];
            end
            default: b = '0;
        endcase
        return b;
    endfunction

    function automatic rtc_time_t rtc_write_field(input rtc_time_t t, input field_e f,
                                                  input logic [BYTE_W-1:0] d);
        rtc_time_t n;
        n = t;
        case (f)
            F_SEC:   n.sec  = d[SEC_W-1:0];
            F_MIN:   n.min  = d[MIN_W-1:0];
            F_HOUR:  n.hour = d[HOUR_W-1:0];
            F_DAYLO: n.day[BYTE_W-1:0] = d;
            F_CTRL: begin
                n.day[DAY_W-1] = d[CTRL_DAY_HI];
                n.halt         = d[CTRL_HALT];
                n.wrap         = t.wrap | d[CTRL_WRAP];
            end
            default: n = t;
        endcase
        return n;
    endfunction

    function automatic logic sel_is_clock(input logic [BYTE_W-1:0] v);
        return (v >= SEL_FIRST) && (v <= SEL_LAST);
    endfunction

    function automatic field_e sel_to_field(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] off;
        off = v - SEL_FIRST;
        return field_e'(off[2:0]);
    endfunction

endpackage

// File: rtl/cart_rtc_map.sv
module cart_rtc_map
    import cart_rtc_pkg::*;
#(
    parameter int ROM_BANK_W = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [1:0]            reg_sel,
    input  logic [BYTE_W-1:0]     reg_wdata,
    output logic                  access_en,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  clk_mode,
    output field_e                field
);

    region_e                rgn;
    logic [ROM_BANK_W-1:0]  rom_req;

    assign rgn     = region_e'(reg_sel);
    assign rom_req = reg_wdata[ROM_BANK_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            access_en <= 1'b0;
            rom_bank  <= ROM_BANK_W'(1);
            ram_bank  <= '0;
            clk_mode  <= 1'b0;
            field     <= F_SEC;
        end else if (reg_we) begin
            case (rgn)
                RGN_ENABLE: access_en <= ((reg_wdata & EN_MASK) == EN_MASK);
                RGN_ROM:    rom_bank  <= (rom_req == '0) ? ROM_BANK_W'(1) : rom_req;
                RGN_MAP: begin
                    if (reg_wdata < BYTE_W'(RAM_BANKS)) begin
                        ram_bank <= reg_wdata[RAM_BANK_W-1:0];
                        clk_mode <= 1'b0;
                    end else if (access_en && sel_is_clock(reg_wdata)) begin
                        clk_mode <= 1'b1;
                        field    <= sel_to_field(reg_wdata);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cart_rtc_counter.sv
module cart_rtc_counter
    import cart_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              field_we,
    input  field_e            field,
    input  logic [BYTE_W-1:0] wdata,
    output rtc_time_t         live
);

    rtc_time_t nxt;

    always_comb begin
        nxt = live;
        if (tick && !live.halt) begin
            nxt = rtc_advance(live);
        end
        if (field_we) begin
            nxt = rtc_write_field(nxt, field, wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else begin
            live <= nxt;
        end
    end

endmodule

// File: rtl/cart_rtc_latch.sv
module cart_rtc_latch
    import cart_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_we,
    input  logic [BYTE_W-1:0] wdata,
    input  rtc_time_t         live,
    output rtc_time_t         snap,
    output logic              stored
);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap   <= '0;
            stored <= 1'b0;
        end else if (latch_we) begin
            if (!stored && (wdata == LATCH_HI)) begin
                snap <= live;
            end
            if (wdata == LATCH_LO) begin
                stored <= 1'b0;
            end else if (wdata == LATCH_HI) begin
                stored <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cart_rtc_regs.sv
module cart_rtc_regs
    import cart_rtc_pkg::*;
#(
    parameter int ROM_BANK_W = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  reg_we,
    input  logic [1:0]            reg_sel,
    input  logic [7:0]            reg_wdata,
    input  logic                  win_we,
    input  logic [7:0]            win_wdata,
    input  logic [7:0]            ram_rdata,
    output logic [7:0]            win_rdata,
    output logic                  ram_we,
    output logic [2:0]            ram_bank,
    output logic [ROM_BANK_W-1:0] rom_bank
);

    logic      access_en;
    logic      clk_mode;
    field_e    field;
    logic      latch_we;
    logic      field_we;
    logic      latch_q;
    rtc_time_t live_t;
    rtc_time_t snap_t;

    assign latch_we = reg_we && (region_e'(reg_sel) == RGN_LATCH);
    assign field_we = win_we && access_en && clk_mode;
    assign ram_we   = win_we && access_en && !clk_mode;

    cart_rtc_map #(.ROM_BANK_W(ROM_BANK_W)) u_map (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .access_en (access_en),
        .rom_bank  (rom_bank),
        .ram_bank  (ram_bank),
        .clk_mode  (clk_mode),
        .field     (field)
    );

    cart_rtc_counter u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .field_we (field_we),
        .field    (field),
        .wdata    (win_wdata),
        .live     (live_t)
    );

    cart_rtc_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .latch_we (latch_we),
        .wdata    (reg_wdata),
        .live     (live_t),
        .snap     (snap_t),
        .stored   (latch_q)
    );

    always_comb begin
        if (!access_en) begin
            win_rdata = '0;
        end else if (clk_mode) begin
            win_rdata = rtc_read_field(snap_t, field);
        end else begin
            win_rdata = ram_rdata;
        end
    end

endmodule

// File: rtl/cart_rtc_regs_chk.sv
module cart_rtc_regs_chk
    import cart_rtc_pkg::*;
#(
    parameter int ROM_BANK_W = 7
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  access_en,
    input logic                  clk_mode,
    input logic                  win_we,
    input logic                  ram_we,
    input logic [7:0]            win_rdata,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic                  latch_we,
    input logic [7:0]            reg_wdata,
    input logic                  latch_q,
    input rtc_time_t             snap,
    input rtc_time_t             live
);

    logic clk_wr;
    assign clk_wr = win_we && access_en && clk_mode;

    // R5: the snapshot moves only on a 0x01 latch write with stored value 0
    a_r5_snap_needs_arm: assert property (@(posedge clk) disable iff (rst)
        (snap != $past(snap)) |-> ($past(latch_we) && ($past(reg_wdata) == 8'h01) && !$past(latch_q)));

    // R9: wrap flag, once set, stays set
    a_r9_wrap_sticky: assert property (@(posedge clk) disable iff (rst)
        live.wrap |=> live.wrap);

    // R2: ROM bank never zero
    a_r2_rom_nonzero: assert property (@(posedge clk) disable iff (rst)
        rom_bank != '0);

    // R10: disabled window reads as zero and never strobes RAM
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !access_en |-> ((win_rdata == 8'h00) && !ram_we));

    // R11: halted counter keeps seconds unless software writes a field
    a_r11_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (live.halt && !clk_wr) |=> (live.sec == $past(live.sec)));

    // R3: RAM strobe only with RAM mapped
    a_r3_ram_we_mapped: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> !clk_mode);

endmodule

bind cart_rtc_regs cart_rtc_regs_chk #(.ROM_BANK_W(ROM_BANK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .access_en (access_en),
    .clk_mode  (clk_mode),
    .win_we    (win_we),
    .ram_we    (ram_we),
    .win_rdata (win_rdata),
    .rom_bank  (rom_bank),
    .latch_we  (latch_we),
    .reg_wdata (reg_wdata),
    .latch_q   (latch_q),
    .snap      (snap_t),
    .live      (live_t)
);

// File: tb/cart_rtc_regs_test.sv
module cart_rtc_regs_test;

    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst;
    logic       tick;
    logic       reg_we;
    logic [1:0] reg_sel;
    logic [7:0] reg_wdata;
    logic       win_we;
    logic [7:0] win_wdata;
    logic [7:0] ram_rdata;
    logic [7:0] win_rdata;
    logic       ram_we;
    logic [2:0] ram_bank;
    logic [6:0] rom_bank;

    cart_rtc_regs uut (
        .clk(clk), .rst(rst), .tick(tick), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .win_we(win_we), .win_wdata(win_wdata),
        .ram_rdata(ram_rdata), .win_rdata(win_rdata), .ram_we(ram_we),
        .ram_bank(ram_bank), .rom_bank(rom_bank)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model state
    int m_en, m_clk, m_field, m_bank, m_rom, m_lq;
    int ms, mm, mh, md, mhalt, mwrap;
    int ls, lm, lh, ld, lhalt, lwrap;
    logic seen_ram_we;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_read();
        if (m_en == 0) return 0;
        if (m_clk != 0) begin
            case (m_field)
                0: return ls;
                1: return lm;
                2: return lh;
                3: return ld & 255;
                default: return (lwrap << 7) | (lhalt << 6) | (ld >> 8);
            endcase
        end
        return int'(ram_rdata);
    endfunction

    task automatic model_tick();
        if (mhalt == 0) begin
            if (ms >= 59) begin
                ms = 0;
                if (mm >= 59) begin
                    mm = 0;
                    if (mh >= 23) begin
                        mh = 0;
                        if (md == 511) begin md = 0; mwrap = 1; end
                        else md++;
                    end else mh++;
                end else mm++;
            end else ms++;
        end
    endtask

    task automatic model_field(input int d);
        case (m_field)
            0: ms = d & 63;
            1: mm = d & 63;
            2: mh = d & 31;
            3: md = (md & 256) | (d & 255);
            default: begin
                md    = (md & 255) | ((d & 1) << 8);
                mhalt = (d >> 6) & 1;
                mwrap = mwrap | ((d >> 7) & 1);
            end
        endcase
    endtask

    task automatic step(input bit t, input bit rwe, input int rs, input int rd,
                        input bit wwe, input int wd);
        tick      = t;
        reg_we    = rwe;
        reg_sel   = 2'(rs);
        reg_wdata = 8'(rd);
        win_we    = wwe;
        win_wdata = 8'(wd);
        #2;
        seen_ram_we = ram_we;
        // model: snapshot from pre-edge time, then counter, then map regs
        if (rwe && rs == 3) begin
            if (m_lq == 0 && rd == 1) begin
                ls = ms; lm = mm; lh = mh; ld = md; lhalt = mhalt; lwrap = mwrap;
            end
            if (rd == 0) m_lq = 0;
            else if (rd == 1) m_lq = 1;
        end
        if (t) model_tick();
        if (wwe && m_en != 0 && m_clk != 0) model_field(wd);
        if (rwe && rs == 0) m_en = ((rd & 8'h0A) == 8'h0A) ? 1 : 0;
        if (rwe && rs == 1) m_rom = ((rd & 127) == 0) ? 1 : (rd & 127);
        if (rwe && rs == 2) begin
            if (rd < 8) begin m_bank = rd; m_clk = 0; end
            else if (m_en != 0 && rd >= 8 && rd <= 12) begin m_clk = 1; m_field = rd - 8; end
        end
        @(posedge clk);
        #1;
        tick = 0; reg_we = 0; win_we = 0;
    endtask

    task automatic wreg(input int rs, input int rd);
        step(0, 1, rs, rd, 0, 0);
    endtask

    task automatic wwin(input int d);
        step(0, 0, 0, 0, 1, d);
    endtask

    task automatic tick1();
        step(1, 0, 0, 0, 0, 0);
    endtask

    task automatic do_latch();
        wreg(3, 0);
        wreg(3, 1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; tick = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
        win_we = 0; win_wdata = 0; ram_rdata = 8'h5A;
        m_en = 0; m_clk = 0; m_field = 0; m_bank = 0; m_rom = 1; m_lq = 0;
        ms = 0; mm = 0; mh = 0; md = 0; mhalt = 0; mwrap = 0;
        ls = 0; lm = 0; lh = 0; ld = 0; lhalt = 0; lwrap = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R12 reset state
        check("R12 read disabled", win_rdata, 8'h00);
        check("R12 rom bank", rom_bank, 7'd1);
        check("R12 ram bank", ram_bank, 3'd0);
        check("R12 ram_we", ram_we, 1'b0);

        // R2 ROM bank
        wreg(1, 8'h85); check("R2 bank 0x85", rom_bank, 7'h05);
        wreg(1, 8'h80); check("R2 masked zero", rom_bank, 7'h01);
        wreg(1, 8'h00); check("R2 zero", rom_bank, 7'h01);
        wreg(1, 8'h7F); check("R2 bank 0x7F", rom_bank, 7'h7F);

        // R1 enable
        wreg(0, 8'h0A); check("R1 enabled RAM read", win_rdata, 8'h5A);
        wreg(0, 8'h1E); check("R1 0x1E enables", win_rdata, 8'h5A);
        wreg(0, 8'h08); check("R1 0x08 disables", win_rdata, 8'h00);
        wreg(0, 8'h0A);

        // R3 RAM bank mapping
        wreg(2, 5); check("R3 ram bank", ram_bank, 3'd5);
        wwin(8'h11); check("R3 ram_we strobe", seen_ram_we, 1'b1);

        // R4 clock select ignored while disabled
        wreg(0, 0); wreg(2, 8); wreg(0, 8'h0A);
        check("R4 select ignored disabled", win_rdata, 8'h5A);
        check("R4 bank kept", ram_bank, 3'd5);

        // R4/R6 select seconds, snapshot still zero
        wreg(2, 8); check("R4 seconds mapped", win_rdata, 8'h00);
        wwin(58); check("R6 snapshot not running", win_rdata, 8'h00);
        check("R7 no ram_we in clock mode", seen_ram_we, 1'b0);
        do_latch(); check("R5 latched seconds", win_rdata, 8'd58);

        // R5 latch sequence rules
        tick1(); tick1();
        wreg(3, 1); check("R5 repeat 1 no copy", win_rdata, 8'd58);
        wreg(3, 2); wreg(3, 1); check("R5 value 2 keeps stored", win_rdata, 8'd58);
        do_latch(); check("R8 seconds rolled", win_rdata, 8'd0);
        wreg(2, 9); check("R8 minute carry", win_rdata, 8'd1);

        // R8 hour and day carry
        wreg(2, 8'h0A); wwin(23);
        wreg(2, 9); wwin(59);
        wreg(2, 8); wwin(59);
        tick1(); do_latch();
        wreg(2, 8'h0A); check("R8 hours wrap", win_rdata, 8'd0);
        wreg(2, 8'h0B); check("R8 day carry", win_rdata, 8'd1);

        // R9 day wrap and sticky flag
        wwin(8'hFF);
        wreg(2, 8'h0C); wwin(8'h01);
        wreg(2, 8); wwin(59);
        wreg(2, 9); wwin(59);
        wreg(2, 8'h0A); wwin(23);
        tick1(); do_latch();
        wreg(2, 8'h0C); check("R9 wrap flag set", win_rdata, 8'h80);
        wreg(2, 8'h0B); check("R9 day wrapped", win_rdata, 8'h00);
        wreg(2, 8'h0C); wwin(8'h00); do_latch();
        check("R9 flag survives write", win_rdata, 8'h80);

        // R11 halt
        wwin(8'h40); tick1(); tick1(); tick1(); do_latch();
        check("R11 control halt", win_rdata, 8'hC0);
        wreg(2, 8); check("R11 seconds frozen", win_rdata, 8'h00);
        wreg(2, 8'h0C); wwin(8'h00);

        // R7 write and tick collide
        wreg(2, 8);
        step(1, 0, 0, 0, 1, 10); do_latch();
        check("R7 write wins on field", win_rdata, 8'd10);
        wwin(59); wreg(2, 9);
        step(1, 0, 0, 0, 1, 20); do_latch();
        check("R7 written minutes", win_rdata, 8'd20);
        wreg(2, 8); check("R7 carry still in seconds", win_rdata, 8'd0);

        // R10 writes ignored while disabled
        wreg(0, 0); wwin(33);
        check("R10 no ram_we disabled", seen_ram_we, 1'b0);
        wreg(0, 8'h0A); do_latch();
        check("R10 seconds untouched", win_rdata, 8'd0);
        wreg(2, 3); check("R3 back to RAM", win_rdata, 8'h5A);
        check("R3 bank 3", ram_bank, 3'd3);
        wreg(0, 0); wwin(8'h77);
        check("R10 RAM write blocked", seen_ram_we, 1'b0);
        wreg(0, 8'h0A);

        // R4 value above 0x0C ignored
        wreg(2, 8); wreg(2, 8'h0D);
        check("R4 0x0D ignored", win_rdata, 8'd0);

        // random phase against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            int r, rs, rd;
            bit t, rwe, wwe;
            r   = $urandom_range(0, 99);
            t   = ($urandom_range(0, 99) < 35);
            rwe = (r < 30);
            wwe = (r >= 30 && r < 50);
            rs  = $urandom_range(0, 3);
            case ($urandom_range(0, 5))
                0: rd = $urandom_range(0, 1);
                1: rd = $urandom_range(8, 12);
                2: rd = 8'h0A;
                3: rd = $urandom_range(0, 7);
                default: rd = $urandom_range(0, 255);
            endcase
            ram_rdata = 8'($urandom_range(0, 255));
            step(t, rwe, rs, rd, wwe, $urandom_range(0, 255));
            check("R6 random read", win_rdata, 32'(exp_read()));
            if (i % 8 == 0) begin
                check("R2 random rom", rom_bank, 32'(m_rom));
                check("R3 random bank", ram_bank, 32'(m_bank));
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule